// File: doc/BRIEF.md
# Masked GPIO Output Port

This block is a general-purpose I/O port whose registers sit on a plain memory-mapped write/read bus with per-byte enables. It keeps an output latch and a direction register. Software can change the latch in four ways: a set register that raises selected bits, a clear register that lowers selected bits, a pin-value register that loads a whole value at once, and a mask register that shields chosen bits from all three. Each register can be written as a full word, as one 16-bit half, or as any single byte, because every byte lane has its own enable.

Pins whose direction bit is 1 drive the latched level. Pins whose direction bit is 0 are not driven, but their latch bits still follow writes, so the stored value appears as soon as the pin is turned into an output. The pad levels pass through a short synchroniser. A read of the pin-value register returns those sampled levels, with every masked bit read as zero.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset the direction, mask and latch are all zero. pad_out and pad_oe are zero, and every register address reads zero while the pads are low.
- R2: A write to the set register (word address 3) makes the latch bit 1 for every bit that is written as 1, sits in an enabled lane and is unmasked. All other latch bits keep their value. The change shows on the clock edge that accepts the write.
- R3: A write to the clear register (word address 4) makes the latch bit 0 for every bit that is written as 1, sits in an enabled lane and is unmasked. All other latch bits keep their value.
- R4: A write to the pin-value register (word address 2) loads the written value into every latch bit that sits in an enabled lane and is unmasked. For example, with mask 0xFFFF00FF a word write of 0x0000A500 changes only bits 15..8, to 0xA5.
- R5: A mask bit of 1 keeps that latch bit unchanged on pin-value, set and clear writes. A mask bit of 0 lets those writes reach the bit.
- R6: Byte enable be[i] covers data bits 8i+7..8i. On every register, bits in lanes whose enable is low are unchanged. A write with only be[1] set writes byte 1 alone. With no write, no register changes.
- R7: pad_oe equals the direction register (1 = output). pad_out equals the latch ANDed with direction. The latch bit of an input pin still updates on writes.
- R8: Reading the pin-value register returns pad_in after two synchroniser stages, ANDed with the inverted mask. A pad change is visible on rdata two clock edges after it is applied.
- R9: Reads are combinational from addr. Address 0 returns direction, address 1 returns mask, address 3 returns the latch, and addresses 4 to 7 return zero. Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, accepted at the rising edge |
| addr | input | 3 | Word address of the register |
| be | input | 4 | Byte-lane enables for the write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| pad_in | input | 32 | Pad levels |
| pad_out | output | 32 | Driven pad levels |
| pad_oe | output | 32 | Per-pin output enable |

## Verification
Register and latch changes are due at the rising edge that accepts the write. The bench therefore drives each write at a falling edge and updates its model right after the next rising edge. It compares pad_out, pad_oe and every register readback at the following falling edge. Pad input changes reach rdata only after two rising edges, so the bench applies a new pad value at a falling edge and waits two rising edges before it reads the pin-value register again. Random writes with mixed lane patterns are combined with directed cases: the half-word mask example, single-byte writes, masked set and clear, writes to input pins, and writes to unused addresses.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_DIR  = 3'd0,
    RA_MASK = 3'd1,
    RA_PIN  = 3'd2,
    RA_SET  = 3'd3,
    RA_CLR  = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic dir;
    logic mask;
    logic pin;
    logic set;
    logic clr;
  } wr_strobe_t;
endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_mask_pkg::*;
(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output wr_strobe_t        strobe
);
  always_comb begin
    strobe = '0;
    if (wr_en) begin
      case (addr)
        RA_DIR:  strobe.dir  = 1'b1;
        RA_MASK: strobe.mask = 1'b1;
        RA_PIN:  strobe.pin  = 1'b1;
        RA_SET:  strobe.set  = 1'b1;
        RA_CLR:  strobe.clr  = 1'b1;
        default: strobe = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [WIDTH-1:0] lanes,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  function automatic logic [WIDTH-1:0] lane_merge(
    input logic [WIDTH-1:0] old_v,
    input logic [WIDTH-1:0] new_v,
    input logic [WIDTH-1:0] sel
  );
    return (old_v & ~sel) | (new_v & sel);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= lane_merge(q, wdata, lanes);
  end
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_pin,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic [WIDTH-1:0] lanes,
  input  logic [WIDTH-1:0] mask,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] latch_q
);
  // Bits a write is allowed to reach: enabled lane and not shielded
  function automatic logic [WIDTH-1:0] reach(
    input logic [WIDTH-1:0] ln,
    input logic [WIDTH-1:0] mk
  );
    return ln & ~mk;
  endfunction

  function automatic logic [WIDTH-1:0] apply_pin(
    input logic [WIDTH-1:0] cur, input logic [WIDTH-1:0] d, input logic [WIDTH-1:0] r
  );
    return (cur & ~r) | (d & r);
  endfunction

  function automatic logic [WIDTH-1:0] apply_set(
    input logic [WIDTH-1:0] cur, input logic [WIDTH-1:0] d, input logic [WIDTH-1:0] r
  );
    return cur | (d & r);
  endfunction

  function automatic logic [WIDTH-1:0] apply_clr(
    input logic [WIDTH-1:0] cur, input logic [WIDTH-1:0] d, input logic [WIDTH-1:0] r
  );
    return cur & ~(d & r);
  endfunction

  logic [WIDTH-1:0] reach_bits;
  logic [WIDTH-1:0] latch_d;

  assign reach_bits = reach(lanes, mask);

  always_comb begin
    latch_d = latch_q;
    if (wr_pin)      latch_d = apply_pin(latch_q, wdata, reach_bits);
    else if (wr_set) latch_d = apply_set(latch_q, wdata, reach_bits);
    else if (wr_clr) latch_d = apply_clr(latch_q, wdata, reach_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= latch_d;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int unsigned WIDTH       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WIDTH/8-1:0]   be,
  input  logic [WIDTH-1:0]     wdata,
  output logic [WIDTH-1:0]     rdata,
  input  logic [WIDTH-1:0]     pad_in,
  output logic [WIDTH-1:0]     pad_out,
  output logic [WIDTH-1:0]     pad_oe
);
  localparam int unsigned NBYTES = WIDTH / 8;

  wr_strobe_t       strobe;
  logic             wr_dir, wr_mask, wr_pin, wr_set, wr_clr;
  logic [WIDTH-1:0] lane_bits;
  logic [WIDTH-1:0] dir_q, mask_q, latch_q, pad_smp;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign lane_bits[8*b +: 8] = {8{be[b]}};
  end

  gpio_reg_decode u_dec (
    .wr_en  (wr_en),
    .addr   (addr),
    .strobe (strobe)
  );

  assign wr_dir  = strobe.dir;
  assign wr_mask = strobe.mask;
  assign wr_pin  = strobe.pin;
  assign wr_set  = strobe.set;
  assign wr_clr  = strobe.clr;

  gpio_cfg_reg #(.WIDTH(WIDTH)) u_dir (
    .clk(clk), .rst_n(rst_n), .we(wr_dir), .lanes(lane_bits), .wdata(wdata), .q(dir_q)
  );

  gpio_cfg_reg #(.WIDTH(WIDTH)) u_mask (
    .clk(clk), .rst_n(rst_n), .we(wr_mask), .lanes(lane_bits), .wdata(wdata), .q(mask_q)
  );

  gpio_out_latch #(.WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr_pin(wr_pin), .wr_set(wr_set), .wr_clr(wr_clr),
    .lanes(lane_bits), .mask(mask_q), .wdata(wdata), .latch_q(latch_q)
  );

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_smp)
  );

  assign pad_oe  = dir_q;
  assign pad_out = latch_q & dir_q;

  always_comb begin
    case (addr)
      RA_DIR:  rdata = dir_q;
      RA_MASK: rdata = mask_q;
      RA_PIN:  rdata = pad_smp & ~mask_q;
      RA_SET:  rdata = latch_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_mask_chk.sv
module gpio_mask_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_dir,
  input logic             wr_mask,
  input logic             wr_pin,
  input logic             wr_set,
  input logic             wr_clr,
  input logic [WIDTH-1:0] wdata,
  input logic [WIDTH-1:0] lane_bits,
  input logic [WIDTH-1:0] mask_q,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] latch_q,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe
);
  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((latch_q & $past(wdata & lane_bits & ~mask_q)) == $past(wdata & lane_bits & ~mask_q)));

  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((latch_q & $past(wdata & lane_bits & ~mask_q)) == '0));

  p_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pin |=> (((latch_q ^ $past(wdata)) & $past(lane_bits & ~mask_q)) == '0));

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pin || wr_set || wr_clr) |=>
      (((latch_q ^ $past(latch_q)) & $past(mask_q | ~lane_bits)) == '0));

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(latch_q) && $stable(dir_q) && $stable(mask_q)));

  p_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & ~pad_oe) == '0));

  p_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_dir, wr_mask, wr_pin, wr_set, wr_clr}));
endmodule

bind gpio_mask_port gpio_mask_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
  .wr_dir(wr_dir), .wr_mask(wr_mask), .wr_pin(wr_pin), .wr_set(wr_set), .wr_clr(wr_clr),
  .wdata(wdata), .lane_bits(lane_bits), .mask_q(mask_q), .dir_q(dir_q),
  .latch_q(latch_q), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/gpio_mask_port_tb.sv
module gpio_mask_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_dir = '0, m_mask = '0, m_lat = '0, m_pad = '0;

  always #2 clk = ~clk;

  gpio_mask_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .be(be), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic logic [31:0] f_lanes(input logic [3:0] e);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) r[i] = e[i/8];
    return r;
  endfunction

  function automatic logic [31:0] f_expect(input logic [2:0] a);
    case (a)
      3'd0: return m_dir;
      3'd1: return m_mask;
      3'd2: return m_pad & ~m_mask;
      3'd3: return m_lat;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_wr(input logic [2:0] a, input logic [3:0] e, input logic [31:0] d);
    logic [31:0] ln = f_lanes(e);
    for (int i = 0; i < 32; i++) begin
      if (ln[i]) begin
        case (a)
          3'd0: m_dir[i] = d[i];
          3'd1: m_mask[i] = d[i];
          3'd2: if (!m_mask[i]) m_lat[i] = d[i];
          3'd3: if (!m_mask[i] && d[i]) m_lat[i] = 1'b1;
          3'd4: if (!m_mask[i] && d[i]) m_lat[i] = 1'b0;
          default: ;
        endcase
      end
    end
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a);
      #1;
      chk(req, rdata, f_expect(3'(a)));
    end
  endtask

  task automatic do_wr(input string req, input logic [2:0] a, input logic [3:0] e,
                       input logic [31:0] d);
    @(negedge clk);
    addr = a; be = e; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    model_wr(a, e, d);
    @(negedge clk);
    wr_en = 1'b0;
    chk({req, " pad_out (R7)"}, pad_out, m_lat & m_dir);
    chk({req, " pad_oe (R7)"}, pad_oe, m_dir);
  endtask

  task automatic set_pad(input logic [31:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (2) @(posedge clk);
    @(negedge clk);
    m_pad = v;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pad_out", pad_out, 32'h0);
    chk("R1 pad_oe", pad_oe, 32'h0);
    read_all("R1 readback");

    // R7 write latch while all pins are inputs, then enable outputs
    do_wr("R7", 3'd2, 4'hF, 32'h1234_5678);
    chk("R7 no drive on inputs", pad_out, 32'h0);
    read_all("R7 latch of input pins");
    do_wr("R7", 3'd0, 4'hF, 32'hFFFF_FFFF);
    chk("R7 stored value driven", pad_out, 32'h1234_5678);

    // R4/R5 mask example with word write
    do_wr("R5", 3'd1, 4'hF, 32'hFFFF_00FF);
    do_wr("R4", 3'd2, 4'hF, 32'h0000_A500);
    chk("R4 mask example", pad_out, 32'h1234_A578);
    // R6 byte write of pin register with mask cleared
    do_wr("R5", 3'd1, 4'hF, 32'h0);
    do_wr("R6", 3'd2, 4'h2, 32'hFFFF_3CFF);
    chk("R6 byte1 only", pad_out, 32'h1234_3C78);
    // R2/R3 set and clear, partly masked
    do_wr("R5", 3'd1, 4'h3, 32'h0000_00F0);
    do_wr("R2", 3'd3, 4'hF, 32'h0000_00FF);
    chk("R2 masked set", pad_out, 32'h1234_3C7F);
    do_wr("R3", 3'd4, 4'hF, 32'hFFFF_FFFF);
    chk("R3 masked clear", pad_out, 32'h0000_0070);
    // R6 half-word write of direction
    do_wr("R6", 3'd0, 4'hC, 32'h0000_FFFF);
    chk("R6 upper half dir", pad_oe, 32'h0000_FFFF);
    // R9 unused addresses ignored
    do_wr("R9", 3'd5, 4'hF, 32'hFFFF_FFFF);
    do_wr("R9", 3'd7, 4'hF, 32'hFFFF_FFFF);
    read_all("R9 after unused writes");
    // R8 pad sampling with mask
    set_pad(32'hDEAD_BEEF);
    read_all("R8 pad read");
    do_wr("R8", 3'd1, 4'hF, 32'hFFFF_0000);
    read_all("R8 masked pad read");

    for (int it = 0; it < 400; it++) begin
      logic [3:0] e;
      case ($urandom_range(0, 7))
        0: e = 4'hF;
        1: e = 4'h3;
        2: e = 4'hC;
        3: e = 4'h1;
        4: e = 4'h2;
        5: e = 4'h4;
        6: e = 4'h8;
        default: e = 4'($urandom_range(0, 15));
      endcase
      do_wr("R6 random", 3'($urandom_range(0, 7)), e, $urandom());
      read_all("R2 R3 R4 R5 random readback");
      if (it % 25 == 0) begin
        set_pad($urandom());
        read_all("R8 random pad");
      end
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule